// File: doc/BRIEF.md
# Quarter-Word Multiply-Accumulate Unit

This block is the multiply-accumulate datapath of a wide-integer arithmetic engine. Each operation takes two 256-bit operand words and picks one 64-bit quarter from each. It multiplies the two quarters into a 128-bit product and moves that product up by a whole number of quarters. It then adds the result to a 256-bit accumulator held inside the block. An optional clear makes the addition start from zero, so the first partial product of a long multiplication can be issued without a separate reset of the accumulator.

Three write-back modes are supported. In the first, only the accumulator is updated. In the second, the full sum is also presented as a destination word. In the third, the low 128 bits of the sum are merged into one half of the supplied destination word, and the accumulator keeps only the bits above 128. That third mode lets a long product be streamed out 128 bits at a time. A two-stage pipeline gives a fixed latency. Back-to-back operations chain through the accumulator with no stall. A separate load port writes the accumulator directly.

Top module: `qw_mac_unit`

## Requirements
- R1: The quarter taken from each operand is bits [sel*64 +: 64], where sel is that operand's 2-bit select; sel 0 is the least significant quarter.
- R2: The 128-bit product is shifted left by shift_sel_i*64 bits (0, 64, 128 or 192) before the addition, and the sum is truncated to 256 bits.
- R3: When zero_acc_i is 1, the addend taken from the accumulator is 0 instead of its current value.
- R4: mode_i = 0 (accumulate) stores the sum in the accumulator and completes with wr_en_o = 0. The accumulator holds its value in any cycle with no completing operation and no load.
- R5: mode_i = 1 (write-out) completes with wr_en_o = 1 and result_o equal to the sum, and stores the same sum in the accumulator.
- R6: mode_i = 2 (shift-out) completes with wr_en_o = 1. The low 128 bits of the sum go to the upper half of result_o when hw_sel_i = 1 and to the lower half when hw_sel_i = 0. The other half equals the same half of dest_i.
- R7: In shift-out mode, the accumulator becomes the sum shifted right by 128 bits.
- R8: valid_o is high for exactly one cycle, two rising edges after the edge that samples start_i. Starts on consecutive cycles each complete in order, and each uses the accumulator left by the one before.
- R9: While rst_ni is low, the accumulator, valid_o and wr_en_o are 0.
- R10: acc_load_i = 1 writes acc_load_data_i into the accumulator at the next edge. This load wins over an operation completing at the same edge, whose result_o is still delivered.
- R11: mode_i = 3 behaves as accumulate mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Issue an operation this cycle |
| op_a_i | input | 256 | First operand word |
| op_b_i | input | 256 | Second operand word |
| a_qsel_i | input | 2 | Quarter select for op_a_i |
| b_qsel_i | input | 2 | Quarter select for op_b_i |
| shift_sel_i | input | 2 | Product shift, in units of 64 bits |
| zero_acc_i | input | 1 | Treat the accumulator as zero for this operation |
| mode_i | input | 2 | 0 accumulate, 1 write-out, 2 shift-out, 3 as 0 |
| hw_sel_i | input | 1 | Shift-out target half: 1 upper, 0 lower |
| dest_i | input | 256 | Current destination contents, for half merging |
| acc_load_i | input | 1 | Direct accumulator write |
| acc_load_data_i | input | 256 | Value for the direct write |
| valid_o | output | 1 | Operation complete this cycle |
| wr_en_o | output | 1 | Destination write requested this cycle |
| result_o | output | 256 | Destination value |
| acc_o | output | 256 | Current accumulator |

## Verification
A wrong accumulator value is the error most likely to stay hidden, because accumulate-mode operations do not expose their sum. It is visible on acc_o from the cycle after the faulty update, and every later sum carries it forward. Long random chains of back-to-back operations with a compare at every cycle therefore catch such a fault within one operation. A stale or misplaced pipeline register shows up on result_o or valid_o exactly two cycles after the affected start, as the wrong quarter, the wrong shift or the wrong merged half.

// File: rtl/qw_mac_pkg.sv
package qw_mac_pkg;
  typedef enum logic [1:0] {
    MAC_ACC  = 2'd0,
    MAC_WOUT = 2'd1,
    MAC_SOUT = 2'd2,
    MAC_ALT  = 2'd3
  } mac_mode_e;
endpackage

// File: rtl/qw_select.sv
module qw_select #(
  parameter int WORD_W = 256,
  parameter int QW_W   = 64,
  localparam int NUM_Q = WORD_W / QW_W,
  localparam int SEL_W = $clog2(NUM_Q)
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [QW_W-1:0]   qw_o
);
  logic [QW_W-1:0] lanes [NUM_Q];

  for (genvar q = 0; q < NUM_Q; q++) begin : g_lane
    assign lanes[q] = word_i[q*QW_W +: QW_W];
  end

  assign qw_o = lanes[sel_i];
endmodule

// File: rtl/qw_mul_stage.sv
module qw_mul_stage
  import qw_mac_pkg::*;
#(
  parameter int WORD_W = 256,
  parameter int QW_W   = 64,
  localparam int NUM_Q  = WORD_W / QW_W,
  localparam int SEL_W  = $clog2(NUM_Q),
  localparam int PROD_W = 2 * QW_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [QW_W-1:0]   a_qw_i,
  input  logic [QW_W-1:0]   b_qw_i,
  input  logic [SEL_W-1:0]  shift_sel_i,
  input  logic              zero_acc_i,
  input  mac_mode_e         mode_i,
  input  logic              hw_sel_i,
  input  logic [WORD_W-1:0] dest_i,
  output logic              vld_o,
  output logic [PROD_W-1:0] prod_o,
  output logic [SEL_W-1:0]  shift_sel_o,
  output logic              zero_acc_o,
  output mac_mode_e         mode_o,
  output logic              hw_sel_o,
  output logic [WORD_W-1:0] dest_o
);
  logic [PROD_W-1:0] prod_d;

  assign prod_d = PROD_W'(a_qw_i) * PROD_W'(b_qw_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o       <= 1'b0;
      prod_o      <= '0;
      shift_sel_o <= '0;
      zero_acc_o  <= 1'b0;
      mode_o      <= MAC_ACC;
      hw_sel_o    <= 1'b0;
      dest_o      <= '0;
    end else begin
      vld_o <= start_i;
      if (start_i) begin
        prod_o      <= prod_d;
        shift_sel_o <= shift_sel_i;
        zero_acc_o  <= zero_acc_i;
        mode_o      <= mode_i;
        hw_sel_o    <= hw_sel_i;
        dest_o      <= dest_i;
      end
    end
  end
endmodule

// File: rtl/qw_acc_stage.sv
module qw_acc_stage
  import qw_mac_pkg::*;
#(
  parameter int WORD_W = 256,
  parameter int QW_W   = 64,
  localparam int NUM_Q  = WORD_W / QW_W,
  localparam int SEL_W  = $clog2(NUM_Q),
  localparam int PROD_W = 2 * QW_W,
  localparam int HW_W   = WORD_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [PROD_W-1:0] prod_i,
  input  logic [SEL_W-1:0]  shift_sel_i,
  input  logic              zero_acc_i,
  input  mac_mode_e         mode_i,
  input  logic              hw_sel_i,
  input  logic [WORD_W-1:0] dest_i,
  input  logic              acc_load_i,
  input  logic [WORD_W-1:0] acc_load_data_i,
  output logic              valid_o,
  output logic              wr_en_o,
  output logic [WORD_W-1:0] result_o,
  output logic [WORD_W-1:0] acc_o
);
  logic [WORD_W-1:0] prod_ext, shifted, base, sum, res_d, acc_nx;
  logic              wr_d;

  assign prod_ext = WORD_W'(prod_i);
  assign shifted  = prod_ext << (32'(shift_sel_i) * QW_W);
  assign base     = zero_acc_i ? '0 : acc_o;
  assign sum      = base + shifted;

  always_comb begin
    res_d  = sum;
    acc_nx = sum;
    wr_d   = 1'b0;
    case (mode_i)
      MAC_WOUT: wr_d = 1'b1;
      MAC_SOUT: begin
        wr_d   = 1'b1;
        acc_nx = sum >> HW_W;
        if (hw_sel_i) res_d = {sum[HW_W-1:0], dest_i[HW_W-1:0]};
        else          res_d = {dest_i[WORD_W-1:HW_W], sum[HW_W-1:0]};
      end
      default: wr_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      wr_en_o  <= 1'b0;
      result_o <= '0;
      acc_o    <= '0;
    end else begin
      valid_o <= vld_i;
      wr_en_o <= vld_i & wr_d;
      if (vld_i) result_o <= res_d;
      if (acc_load_i)  acc_o <= acc_load_data_i;
      else if (vld_i)  acc_o <= acc_nx;
    end
  end
endmodule

// File: rtl/qw_mac_unit.sv
module qw_mac_unit
  import qw_mac_pkg::*;
#(
  parameter int WORD_W = 256,
  parameter int QW_W   = 64,
  localparam int NUM_Q  = WORD_W / QW_W,
  localparam int SEL_W  = $clog2(NUM_Q),
  localparam int PROD_W = 2 * QW_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] op_a_i,
  input  logic [WORD_W-1:0] op_b_i,
  input  logic [SEL_W-1:0]  a_qsel_i,
  input  logic [SEL_W-1:0]  b_qsel_i,
  input  logic [SEL_W-1:0]  shift_sel_i,
  input  logic              zero_acc_i,
  input  logic [1:0]        mode_i,
  input  logic              hw_sel_i,
  input  logic [WORD_W-1:0] dest_i,
  input  logic              acc_load_i,
  input  logic [WORD_W-1:0] acc_load_data_i,
  output logic              valid_o,
  output logic              wr_en_o,
  output logic [WORD_W-1:0] result_o,
  output logic [WORD_W-1:0] acc_o
);
  logic [QW_W-1:0]   a_qw, b_qw;
  logic              s1_vld, s1_zero, s1_hw_sel;
  logic [PROD_W-1:0] s1_prod;
  logic [SEL_W-1:0]  s1_shift;
  mac_mode_e         s1_mode;
  logic [WORD_W-1:0] s1_dest;

  qw_select #(.WORD_W(WORD_W), .QW_W(QW_W)) u_sel_a (
    .word_i(op_a_i), .sel_i(a_qsel_i), .qw_o(a_qw)
  );

  qw_select #(.WORD_W(WORD_W), .QW_W(QW_W)) u_sel_b (
    .word_i(op_b_i), .sel_i(b_qsel_i), .qw_o(b_qw)
  );

  qw_mul_stage #(.WORD_W(WORD_W), .QW_W(QW_W)) u_mul (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .a_qw_i      (a_qw),
    .b_qw_i      (b_qw),
    .shift_sel_i (shift_sel_i),
    .zero_acc_i  (zero_acc_i),
    .mode_i      (mac_mode_e'(mode_i)),
    .hw_sel_i    (hw_sel_i),
    .dest_i      (dest_i),
    .vld_o       (s1_vld),
    .prod_o      (s1_prod),
    .shift_sel_o (s1_shift),
    .zero_acc_o  (s1_zero),
    .mode_o      (s1_mode),
    .hw_sel_o    (s1_hw_sel),
    .dest_o      (s1_dest)
  );

  qw_acc_stage #(.WORD_W(WORD_W), .QW_W(QW_W)) u_acc (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .vld_i           (s1_vld),
    .prod_i          (s1_prod),
    .shift_sel_i     (s1_shift),
    .zero_acc_i      (s1_zero),
    .mode_i          (s1_mode),
    .hw_sel_i        (s1_hw_sel),
    .dest_i          (s1_dest),
    .acc_load_i      (acc_load_i),
    .acc_load_data_i (acc_load_data_i),
    .valid_o         (valid_o),
    .wr_en_o         (wr_en_o),
    .result_o        (result_o),
    .acc_o           (acc_o)
  );
endmodule

// File: rtl/qw_mac_unit_chk.sv
module qw_mac_unit_chk
  import qw_mac_pkg::*;
#(
  parameter int WORD_W = 256,
  localparam int HW_W  = WORD_W / 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              acc_load_i,
  input logic [WORD_W-1:0] acc_load_data_i,
  input logic              valid_o,
  input logic              wr_en_o,
  input logic [WORD_W-1:0] result_o,
  input logic [WORD_W-1:0] acc_o,
  input logic              s1_vld,
  input mac_mode_e         s1_mode,
  input logic              s1_hw_sel,
  input logic [WORD_W-1:0] s1_dest
);
  p_issue_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> s1_vld);

  p_complete_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_vld |=> valid_o);

  p_no_spurious_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s1_vld |=> !valid_o && !wr_en_o);

  p_acc_no_wr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_vld && s1_mode != MAC_WOUT && s1_mode != MAC_SOUT |=> !wr_en_o);

  p_acc_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s1_vld && !acc_load_i |=> $stable(acc_o));

  p_wout_match_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_vld && s1_mode == MAC_WOUT && !acc_load_i |=> wr_en_o && acc_o == result_o);

  p_keep_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_vld && s1_mode == MAC_SOUT && s1_hw_sel
    |=> result_o[HW_W-1:0] == $past(s1_dest[HW_W-1:0]));

  p_keep_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_vld && s1_mode == MAC_SOUT && !s1_hw_sel
    |=> result_o[WORD_W-1:HW_W] == $past(s1_dest[WORD_W-1:HW_W]));

  p_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_load_i |=> acc_o == $past(acc_load_data_i));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_r9: assert (acc_o == '0 && !valid_o && !wr_en_o);
    end
  end
endmodule

bind qw_mac_unit qw_mac_unit_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .start_i         (start_i),
  .acc_load_i      (acc_load_i),
  .acc_load_data_i (acc_load_data_i),
  .valid_o         (valid_o),
  .wr_en_o         (wr_en_o),
  .result_o        (result_o),
  .acc_o           (acc_o),
  .s1_vld          (s1_vld),
  .s1_mode         (s1_mode),
  .s1_hw_sel       (s1_hw_sel),
  .s1_dest         (s1_dest)
);

// File: tb/qw_mac_unit_test.sv
`timescale 1ns/1ps
module qw_mac_unit_test;
  logic         clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [255:0] op_a_i = '0, op_b_i = '0, dest_i = '0, acc_load_data_i = '0;
  logic [1:0]   a_qsel_i = '0, b_qsel_i = '0, shift_sel_i = '0, mode_i = '0;
  logic         zero_acc_i = 1'b0, hw_sel_i = 1'b0, acc_load_i = 1'b0;
  logic         valid_o, wr_en_o;
  logic [255:0] result_o, acc_o;

  int tests = 0, fails = 0;
  logic [255:0] model_acc = '0;

  always #4 clk_i = ~clk_i;

  qw_mac_unit uut (.*);

  typedef struct {
    logic v; logic wr; logic [255:0] res; logic [255:0] acc;
  } exp_t;

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [255:0] rand256();
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  // Expected completion of one op from the requirements; advances model_acc.
  function automatic exp_t predict(input logic [255:0] a, b, d,
                                   input logic [1:0] qa, qb, sh, md,
                                   input logic z, hw);
    exp_t e;
    logic [127:0] p;
    logic [255:0] s;
    p = 128'(a[qa*64 +: 64]) * 128'(b[qb*64 +: 64]);
    s = (z ? 256'd0 : model_acc) + (256'(p) << (sh * 64));
    e.v = 1'b1;
    e.res = s;
    e.acc = s;
    e.wr = (md == 2'd1 || md == 2'd2);
    if (md == 2'd2) begin
      e.acc = s >> 128;
      e.res = hw ? {s[127:0], d[127:0]} : {d[255:128], s[127:0]};
    end
    model_acc = e.acc;
    return e;
  endfunction

  task automatic drive(input logic [255:0] a, b, d, input logic [1:0] qa, qb, sh, md,
                       input logic z, hw);
    start_i = 1'b1; op_a_i = a; op_b_i = b; dest_i = d; a_qsel_i = qa;
    b_qsel_i = qb; shift_sel_i = sh; mode_i = md; zero_acc_i = z; hw_sel_i = hw;
  endtask

  task automatic check_done(input exp_t e, input string req);
    chk(valid_o == 1'b1, req, "valid_o", 256'(valid_o), 256'd1);
    chk(wr_en_o == e.wr, req, "wr_en_o", 256'(wr_en_o), 256'(e.wr));
    if (e.wr) chk(result_o == e.res, req, "result_o", result_o, e.res);
    chk(acc_o == e.acc, req, "acc_o", acc_o, e.acc);
  endtask

  // Drive at a negedge, check the idle cycle, check completion two negedges later.
  task automatic single_op(input logic [255:0] a, b, d, input logic [1:0] qa, qb, sh, md,
                           input logic z, hw, input string req);
    exp_t e;
    drive(a, b, d, qa, qb, sh, md, z, hw);
    e = predict(a, b, d, qa, qb, sh, md, z, hw);
    @(negedge clk_i);
    start_i = 1'b0;
    chk(valid_o == 1'b0, "R8", "valid_o early", 256'(valid_o), 256'd0);
    @(negedge clk_i);
    check_done(e, req);
    @(negedge clk_i);
    chk(valid_o == 1'b0, "R8", "valid_o single", 256'(valid_o), 256'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL R8 watchdog act=%h exp=%h", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    exp_t e, pipe0, pipe1;
    logic [255:0] ld, last_acc;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    chk(acc_o == '0, "R9", "acc_o in reset", acc_o, '0);
    chk(valid_o == 1'b0, "R9", "valid_o in reset", 256'(valid_o), '0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 R3 R5: top quarter of a, bottom of b, cleared accumulator, write-out
    single_op({64'hFFFF_FFFF_FFFF_FFFF, 192'd5}, {192'd9, 64'h1234_5678_9ABC_DEF0},
              '0, 2'd3, 2'd0, 2'd0, 2'd1, 1'b1, 1'b0, "R1 R3 R5");
    // R2: top shift truncates the upper product half; R4 accumulate-only
    single_op({192'd0, 64'hFFFF_FFFF_FFFF_FFFF}, {128'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0},
              '0, 2'd0, 2'd1, 2'd3, 2'd0, 1'b0, 1'b0, "R2 R4");
    single_op({128'd0, 64'h8000_0000_0000_0001, 64'd0}, {64'd3, 192'd0},
              '0, 2'd1, 2'd3, 2'd1, 2'd1, 1'b0, 1'b0, "R2 R5");
    // R6 R7: shift-out into upper then lower half
    single_op(rand256(), rand256(), {128'hAAAA, 128'h5555}, 2'd2, 2'd1, 2'd2, 2'd2,
              1'b0, 1'b1, "R6 R7 upper");
    single_op(rand256(), rand256(), {128'hCCCC, 128'h3333}, 2'd0, 2'd3, 2'd3, 2'd2,
              1'b0, 1'b0, "R6 R7 lower");
    // R11: mode 3 acts as accumulate
    single_op(rand256(), rand256(), rand256(), 2'd1, 2'd2, 2'd1, 2'd3, 1'b0, 1'b0, "R11");

    // R10: direct load while idle
    ld = rand256();
    acc_load_i = 1'b1; acc_load_data_i = ld;
    @(negedge clk_i);
    acc_load_i = 1'b0;
    chk(acc_o == ld, "R10", "acc_o after load", acc_o, ld);
    model_acc = ld;
    // R10: load at the completion edge wins, result still delivered
    drive(rand256(), rand256(), '0, 2'd0, 2'd0, 2'd0, 2'd1, 1'b0, 1'b0);
    e = predict(op_a_i, op_b_i, dest_i, 2'd0, 2'd0, 2'd0, 2'd1, 1'b0, 1'b0);
    @(negedge clk_i);
    start_i = 1'b0;
    ld = rand256();
    acc_load_i = 1'b1; acc_load_data_i = ld;
    @(negedge clk_i);
    acc_load_i = 1'b0;
    chk(valid_o && result_o == e.res, "R10", "result with load", result_o, e.res);
    chk(acc_o == ld, "R10", "load wins", acc_o, ld);
    model_acc = ld;
    @(negedge clk_i);
    chk(acc_o == ld, "R4", "acc_o hold idle", acc_o, ld);

    // R8 with R1-R7: random back-to-back stream with gaps
    pipe0.v = 1'b0; pipe1.v = 1'b0;
    last_acc = model_acc;
    for (int i = 0; i < 3000; i++) begin
      if (pipe1.v) begin
        check_done(pipe1, "R8 R1 R2 R3 R6 R7 stream");
        last_acc = pipe1.acc;
      end else begin
        chk(valid_o == 1'b0, "R8", "valid_o gap", 256'(valid_o), '0);
        chk(acc_o == last_acc, "R4", "acc_o gap", acc_o, last_acc);
      end
      pipe1 = pipe0;
      if (i < 2998 && ($urandom % 4) != 0) begin
        drive(rand256(), rand256(), rand256(), 2'($urandom), 2'($urandom), 2'($urandom),
              2'($urandom), ($urandom % 5) == 0, 1'($urandom));
        pipe0 = predict(op_a_i, op_b_i, dest_i, a_qsel_i, b_qsel_i, shift_sel_i,
                        mode_i, zero_acc_i, hw_sel_i);
      end else begin
        start_i = 1'b0;
        pipe0.v = 1'b0;
      end
      @(negedge clk_i);
    end

    // R9: reset mid-run clears state
    drive(rand256(), rand256(), '0, 2'd1, 2'd1, 2'd0, 2'd1, 1'b0, 1'b0);
    @(negedge clk_i);
    start_i = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(acc_o == '0, "R9", "acc_o after reset", acc_o, '0);
    chk(valid_o == 1'b0 && wr_en_o == 1'b0, "R9", "valid/wr after reset",
        256'({valid_o, wr_en_o}), '0);
    rst_ni = 1'b1;
    model_acc = '0;
    @(negedge clk_i);
    single_op(rand256(), rand256(), '0, 2'd2, 2'd2, 2'd0, 2'd1, 1'b0, 1'b0, "R9 R5 post");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule